// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel NOR flash. It watches write cycles on a 19-bit address bus and an 8-bit data bus. A write counts when the write strobe rises while chip select is low. The block matches the multi-write unlock handshakes that guard every modifying command. When a handshake completes, it issues a one-cycle start pulse with a command code, the address and data of the write that completed the command, and an 8-bit mask of the 64K-byte sectors that the command touches.

The sector number is taken from the top three address bits. A sector erase can collect several sectors: each further sector write that arrives before a quiet timer runs out adds one more bit to the mask. The block also tracks whether an operation is in progress (`busy`) and whether an erase has been paused (`suspended`). An external array model reports completion through `done`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `busy`, `suspended`, `cmd_start` and `sector_mask` are all 0, and the decoder waits for the first write of a sequence.
- R2: A write is taken on the cycle in which `we_n` is high after being low in the previous cycle, while `ce_n` is low. Strobes with `ce_n` high have no effect.
- R3: The writes AAh@5555h, 55h@2AAAh, A0h@5555h followed by any data at any address give `cmd_start`=1 with `cmd_code`=1 (program) in the cycle after the final write is taken. `op_addr` and `op_data` equal that final write, `sector_mask` has only bit addr[18:16] set, and `busy` becomes 1 in the same cycle.
- R4: Only addr[14:0] is compared with 5555h and 2AAAh. Bits 18..15 of unlock writes do not matter.
- R5: The erase setup (AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh) followed by 10h@5555h gives `cmd_code`=2 (chip erase) with `sector_mask`=FFh. `busy` becomes 1.
- R6: The erase setup followed by 30h at any address opens a collection window. Each further 30h write adds bit addr[18:16] to the mask and restarts the timer. `cmd_code`=3 (sector erase) pulses exactly TIMEOUT cycles after the last 30h write is taken, with the accumulated mask.
- R7: A wrong address or wrong data at any unlock or command step aborts the sequence with no start pulse. The next sequence is then decoded from its first write.
- R8: F0h written as a single write when idle, or after the two unlock writes, pulses `cmd_code`=0 (reset) and leaves the decoder idle.
- R9: While `busy` is 1, every write except suspend is ignored. `done` clears `busy`.
- R10: B0h, written while an erase is running and not suspended, pulses `cmd_code`=4 (suspend), sets `suspended` and clears `busy`. At any other time B0h does nothing.
- R11: While suspended, a program sequence is accepted and an erase setup is aborted. 30h written while suspended and not busy pulses `cmd_code`=5 (resume), sets `busy` and clears `suspended`. At any other time a lone 30h does nothing.
- R12: At most one command fires per cycle, and each start pulse lasts one cycle.
- R13: During the collection window, a write other than 30h discards the collected sectors with no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low; the rising edge takes the write |
| addr | input | 19 | Byte address |
| din | input | 8 | Write data |
| done | input | 1 | Operation complete, from the array model |
| cmd_start | output | 1 | One-cycle start pulse |
| cmd_code | output | 3 | Command code (0 reset, 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume) |
| op_addr | output | 19 | Address of the write that completed the command |
| op_data | output | 8 | Data of that write |
| sector_mask | output | 8 | Selected sectors |
| busy | output | 1 | Operation in progress |
| suspended | output | 1 | Erase paused |

## Verification
A write is taken at the first clock edge that sees `we_n` high after it was low. Every decoded result (`cmd_start`, the code, address, data, mask, `busy` and `suspended`) therefore appears right after that edge. The bench samples at the falling edge that follows. The sector erase is the exception: it fires exactly TIMEOUT edges after the last 30h write. The bench counts falling edges from the sample point of that write and requires the pulse on count TIMEOUT, no earlier and no later. For the ignore cases, the bench samples every write's start pulse and then reads the state flags at the same points.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_RESET        = 3'd0,
    CMD_PROGRAM      = 3'd1,
    CMD_CHIP_ERASE   = 3'd2,
    CMD_SECTOR_ERASE = 3'd3,
    CMD_SUSPEND      = 3'd4,
    CMD_RESUME       = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PGM_DATA,
    S_ER_SETUP, S_ER_UNL1, S_ER_UNL2, S_SECT_WIN
  } seq_e;

  localparam logic [15:0] KEY_ADDR_A = 16'h5555;
  localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;

  localparam logic [7:0] KEY_DATA_A  = 8'hAA;
  localparam logic [7:0] KEY_DATA_B  = 8'h55;
  localparam logic [7:0] OP_PROGRAM  = 8'hA0;
  localparam logic [7:0] OP_ER_SETUP = 8'h80;
  localparam logic [7:0] OP_CHIP     = 8'h10;
  localparam logic [7:0] OP_SECTOR   = 8'h30;
  localparam logic [7:0] OP_SUSPEND  = 8'hB0;
  localparam logic [7:0] OP_RESET    = 8'hF0;

endpackage

// File: rtl/flash_wr_strobe.sv
module flash_wr_strobe #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  logic we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  assign wr_evt  = !ce_n && we_n && !we_q;
  assign wr_addr = addr;
  assign wr_data = din;

  // R2: a write is only taken on a strobe that was low one cycle earlier
  a_r2_strobe_edge: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> !$past(we_n));
  // R2: no write is taken while chip select is high
  a_r2_ce_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !wr_evt);
endmodule

// File: rtl/flash_op_tracker.sv
module flash_op_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic go_pgm,
  input  logic go_erase,
  input  logic go_suspend,
  input  logic go_resume,
  input  logic done,
  output logic busy,
  output logic erasing,
  output logic suspended
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      erasing   <= 1'b0;
      suspended <= 1'b0;
    end else begin
      if (done && busy) begin
        busy <= 1'b0;
        if (!suspended) erasing <= 1'b0;
      end
      if (go_pgm) busy <= 1'b1;
      if (go_erase) begin
        busy    <= 1'b1;
        erasing <= 1'b1;
      end
      if (go_suspend) begin
        busy      <= 1'b0;
        suspended <= 1'b1;
      end
      if (go_resume) begin
        busy      <= 1'b1;
        suspended <= 1'b0;
      end
    end
  end

  // R9: busy only rises because a command was started
  a_r9_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go_pgm || go_erase || go_resume));
  // R10: suspend pauses the erase and frees the bus
  a_r10_suspend_state: assert property (@(posedge clk) disable iff (!rst_n)
    go_suspend |=> (suspended && !busy));
  // R10: a paused erase is still an erase in progress
  a_r10_suspend_owner: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> erasing);
  // R11: resume restarts the erase
  a_r11_resume_state: assert property (@(posedge clk) disable iff (!rst_n)
    go_resume |=> (busy && !suspended));
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int SECT_W  = 3,
  parameter int CMP_W   = 15,
  parameter int TIMEOUT = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_evt,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [7:0]               wr_data,
  input  logic                     busy,
  input  logic                     erasing,
  input  logic                     suspended,
  output logic                     fire_pgm,
  output logic                     fire_chip,
  output logic                     fire_sect,
  output logic                     fire_susp,
  output logic                     fire_resume,
  output logic                     fire_reset,
  output logic                     cmd_start,
  output cmd_e                     cmd_code,
  output logic [ADDR_W-1:0]        op_addr,
  output logic [7:0]               op_data,
  output logic [(1<<SECT_W)-1:0]   sector_mask
);
  localparam int NSECT = 1 << SECT_W;
  localparam int TW    = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CMP_W-1:0] KA = CMP_W'(KEY_ADDR_A);
  localparam logic [CMP_W-1:0] KB = CMP_W'(KEY_ADDR_B);

  // unlock/command cycle match on the low address bits only
  function automatic logic key_hit(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                                   input logic [CMP_W-1:0] ka, input logic [7:0] kd);
    return (a[CMP_W-1:0] == ka) && (d == kd);
  endfunction

  // one-hot sector select from the top address bits
  function automatic logic [NSECT-1:0] sect_bit(input logic [ADDR_W-1:0] a);
    return NSECT'(1) << a[ADDR_W-1 -: SECT_W];
  endfunction

  seq_e              state, state_d;
  logic [NSECT-1:0]  win_mask, win_mask_d;
  logic [TW-1:0]     tmr, tmr_d;
  logic [ADDR_W-1:0] win_addr, win_addr_d;
  logic              any_fire;

  always_comb begin
    state_d     = state;
    win_mask_d  = win_mask;
    tmr_d       = tmr;
    win_addr_d  = win_addr;
    fire_pgm    = 1'b0;
    fire_chip   = 1'b0;
    fire_sect   = 1'b0;
    fire_susp   = 1'b0;
    fire_resume = 1'b0;
    fire_reset  = 1'b0;
    if (state == S_SECT_WIN) begin
      if (wr_evt) begin
        if (wr_data == OP_SECTOR) begin
          win_mask_d = win_mask | sect_bit(wr_addr);
          win_addr_d = wr_addr;
          tmr_d      = '0;
        end else begin
          state_d    = S_IDLE;
          win_mask_d = '0;
        end
      end else if (tmr == TW'(TIMEOUT - 1)) begin
        fire_sect  = 1'b1;
        state_d    = S_IDLE;
        win_mask_d = '0;
      end else begin
        tmr_d = tmr + TW'(1);
      end
    end else if (wr_evt) begin
      unique case (state)
        S_IDLE: begin
          if (busy) begin
            if (wr_data == OP_SUSPEND && erasing && !suspended) fire_susp = 1'b1;
          end else if (key_hit(wr_addr, wr_data, KA, KEY_DATA_A)) begin
            state_d = S_UNL1;
          end else if (wr_data == OP_RESET) begin
            fire_reset = 1'b1;
          end else if (wr_data == OP_SECTOR && suspended) begin
            fire_resume = 1'b1;
          end
        end
        S_UNL1: state_d = key_hit(wr_addr, wr_data, KB, KEY_DATA_B) ? S_UNL2 : S_IDLE;
        S_UNL2: begin
          state_d = S_IDLE;
          if (key_hit(wr_addr, wr_data, KA, OP_PROGRAM))
            state_d = S_PGM_DATA;
          else if (key_hit(wr_addr, wr_data, KA, OP_ER_SETUP) && !suspended)
            state_d = S_ER_SETUP;
          else if (key_hit(wr_addr, wr_data, KA, OP_RESET))
            fire_reset = 1'b1;
        end
        S_PGM_DATA: begin
          fire_pgm = 1'b1;
          state_d  = S_IDLE;
        end
        S_ER_SETUP: state_d = key_hit(wr_addr, wr_data, KA, KEY_DATA_A) ? S_ER_UNL1 : S_IDLE;
        S_ER_UNL1:  state_d = key_hit(wr_addr, wr_data, KB, KEY_DATA_B) ? S_ER_UNL2 : S_IDLE;
        S_ER_UNL2: begin
          state_d = S_IDLE;
          if (key_hit(wr_addr, wr_data, KA, OP_CHIP)) begin
            fire_chip = 1'b1;
          end else if (wr_data == OP_SECTOR) begin
            state_d    = S_SECT_WIN;
            win_mask_d = sect_bit(wr_addr);
            win_addr_d = wr_addr;
            tmr_d      = '0;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  assign any_fire = fire_pgm | fire_chip | fire_sect | fire_susp | fire_resume | fire_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      win_mask    <= '0;
      tmr         <= '0;
      win_addr    <= '0;
      cmd_start   <= 1'b0;
      cmd_code    <= CMD_RESET;
      op_addr     <= '0;
      op_data     <= '0;
      sector_mask <= '0;
    end else begin
      state     <= state_d;
      win_mask  <= win_mask_d;
      tmr       <= tmr_d;
      win_addr  <= win_addr_d;
      cmd_start <= any_fire;
      if (fire_pgm) begin
        cmd_code    <= CMD_PROGRAM;
        op_addr     <= wr_addr;
        op_data     <= wr_data;
        sector_mask <= sect_bit(wr_addr);
      end
      if (fire_chip) begin
        cmd_code    <= CMD_CHIP_ERASE;
        op_addr     <= wr_addr;
        op_data     <= wr_data;
        sector_mask <= '1;
      end
      if (fire_sect) begin
        cmd_code    <= CMD_SECTOR_ERASE;
        op_addr     <= win_addr;
        op_data     <= OP_SECTOR;
        sector_mask <= win_mask;
      end
      if (fire_susp)   cmd_code <= CMD_SUSPEND;
      if (fire_resume) cmd_code <= CMD_RESUME;
      if (fire_reset)  cmd_code <= CMD_RESET;
    end
  end

  // R12: never two commands in one cycle
  a_r12_one_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fire_pgm, fire_chip, fire_sect, fire_susp, fire_resume, fire_reset}));
  // R6: an open window always holds at least one sector
  a_r6_win_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SECT_WIN) |-> (win_mask != '0));
  // R6: the window timer stays inside its limit
  a_r6_tmr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tmr) < TIMEOUT);
  // R5: chip erase selects every sector
  a_r5_chip_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_code == CMD_CHIP_ERASE) |-> (&sector_mask));
  // R9: program and erase never start on top of a running operation
  a_r9_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_pgm || fire_chip || fire_resume) |-> !busy);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int SECT_W  = 3,
  parameter int CMP_W   = 15,
  parameter int TIMEOUT = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_n,
  input  logic                   we_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             din,
  input  logic                   done,
  output logic                   cmd_start,
  output logic [2:0]             cmd_code,
  output logic [ADDR_W-1:0]      op_addr,
  output logic [7:0]             op_data,
  output logic [(1<<SECT_W)-1:0] sector_mask,
  output logic                   busy,
  output logic                   suspended
);
  logic              wr_evt;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              erasing;
  logic              fire_pgm, fire_chip, fire_sect, fire_susp, fire_resume, fire_reset;
  cmd_e              code_q;

  flash_wr_strobe #(.ADDR_W(ADDR_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  flash_seq_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .CMP_W(CMP_W), .TIMEOUT(TIMEOUT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .erasing(erasing), .suspended(suspended),
    .fire_pgm(fire_pgm), .fire_chip(fire_chip), .fire_sect(fire_sect),
    .fire_susp(fire_susp), .fire_resume(fire_resume), .fire_reset(fire_reset),
    .cmd_start(cmd_start), .cmd_code(code_q), .op_addr(op_addr), .op_data(op_data),
    .sector_mask(sector_mask)
  );

  flash_op_tracker u_track (
    .clk(clk), .rst_n(rst_n), .go_pgm(fire_pgm), .go_erase(fire_chip | fire_sect),
    .go_suspend(fire_susp), .go_resume(fire_resume), .done(done),
    .busy(busy), .erasing(erasing), .suspended(suspended)
  );

  assign cmd_code = code_q;

  // R3: a program start is accompanied by busy
  a_r3_busy_with_pgm: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_code == 3'd1) |-> busy);
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int CLK_NS = 10;
  localparam int TO     = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, done = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  din = '0;
  logic        cmd_start, busy, suspended;
  logic [2:0]  cmd_code;
  logic [18:0] op_addr;
  logic [7:0]  op_data, sector_mask;

  int n_tests = 0, n_fail = 0;
  logic        s_start, s_busy, s_susp;
  logic [2:0]  s_code;
  logic [18:0] s_addr;
  logic [7:0]  s_data, s_mask;

  always #(CLK_NS/2) clk = ~clk;

  flash_cmd_decoder #(.TIMEOUT(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .done(done), .cmd_start(cmd_start), .cmd_code(cmd_code), .op_addr(op_addr),
    .op_data(op_data), .sector_mask(sector_mask), .busy(busy), .suspended(suspended)
  );

  function automatic logic [7:0] exp_mask(input logic [18:0] a);
    logic [7:0] m = '0;
    m[a[18:16]] = 1'b1;
    return m;
  endfunction

  function automatic logic [18:0] key(input logic [14:0] low);
    return {4'($urandom), low};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic snap();
    s_start = cmd_start; s_code = cmd_code; s_addr = op_addr; s_data = op_data;
    s_mask = sector_mask; s_busy = busy; s_susp = suspended;
  endtask

  task automatic wr_ce(input logic [18:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk); ce_n = !sel; we_n = 1'b0; addr = a; din = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); snap(); ce_n = 1'b1;
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    wr_ce(a, d, 1'b1);
  endtask

  task automatic unlock2();
    wr(key(15'h5555), 8'hAA); wr(key(15'h2AAA), 8'h55);
  endtask

  task automatic erase_setup();
    unlock2(); wr(key(15'h5555), 8'h80); unlock2();
  endtask

  task automatic finish_op(input string tag);
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    chk(tag, busy, 0);
  endtask

  // unlock/command steps of program (kind 0) and chip erase (kind 1)
  function automatic void step(input int kind, input int i,
                               output logic [14:0] a, output logic [7:0] d);
    if (i == 0 || i == 3)      begin a = 15'h5555; d = 8'hAA; end
    else if (i == 1 || i == 4) begin a = 15'h2AAA; d = 8'h55; end
    else if (i == 2)           begin a = 15'h5555; d = (kind == 0) ? 8'hA0 : 8'h80; end
    else                       begin a = 15'h5555; d = 8'h10; end
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [18:0] ta;
    logic [7:0]  td;
    int got;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 start", cmd_start, 0); chk("R1 busy", busy, 0);
    chk("R1 susp", suspended, 0);  chk("R1 mask", sector_mask, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 start after release", cmd_start, 0);

    // R3 program, with high unlock bits varied (R4)
    unlock2(); wr(key(15'h5555), 8'hA0);
    chk("R4 no early start", s_start, 0);
    wr(19'h5_1234, 8'h3C);
    chk("R3 start", s_start, 1); chk("R3 code", s_code, 1);
    chk("R3 addr", s_addr, 19'h5_1234); chk("R3 data", s_data, 8'h3C);
    chk("R3 mask", s_mask, exp_mask(19'h5_1234)); chk("R3 busy", s_busy, 1);
    @(negedge clk); chk("R12 pulse width", cmd_start, 0);

    // R9 writes ignored while busy
    unlock2(); wr(key(15'h5555), 8'hA0); wr(19'h0_0001, 8'h11);
    chk("R9 ignored while busy", s_start, 0);
    wr(19'h0, 8'hF0); chk("R9 reset ignored while busy", s_start, 0);
    finish_op("R9 done clears busy");

    // R2 strobes with chip select high
    wr_ce(19'h5555, 8'hAA, 1'b0); wr_ce(19'h2AAA, 8'h55, 1'b0);
    wr_ce(19'h5555, 8'hA0, 1'b0); wr_ce(19'h1_0000, 8'h22, 1'b0);
    chk("R2 no start ce high", s_start, 0); chk("R2 busy", s_busy, 0);

    // R7 wrong data on second unlock, then a clean sequence
    wr(19'h5555, 8'hAA); wr(19'h2AAA, 8'h54); wr(19'h5555, 8'hA0); wr(19'h2_0000, 8'h77);
    chk("R7 aborted", s_start, 0);
    unlock2(); wr(19'h5555, 8'hA0); wr(19'h2_0000, 8'h77);
    chk("R7 recover start", s_start, 1); chk("R7 recover code", s_code, 1);
    finish_op("R7 done");

    // R8 reset as single write and after unlocks
    wr(19'h7_0ABC, 8'hF0);
    chk("R8 single start", s_start, 1); chk("R8 single code", s_code, 0);
    unlock2(); wr(key(15'h5555), 8'hF0);
    chk("R8 unlocked start", s_start, 1); chk("R8 unlocked code", s_code, 0);

    // R5 chip erase
    erase_setup(); wr(key(15'h5555), 8'h10);
    chk("R5 start", s_start, 1); chk("R5 code", s_code, 2);
    chk("R5 mask", s_mask, 8'hFF); chk("R5 busy", s_busy, 1);
    finish_op("R5 done");

    // R6 sector erase of sectors 2, 5, 7 with exact timeout
    erase_setup(); wr(19'h2_0040, 8'h30);
    chk("R6 no start yet", s_start, 0);
    wr(19'h5_1111, 8'h30); wr(19'h7_FFFF, 8'h30);
    chk("R6 no start in window", s_start, 0);
    got = 0;
    for (int n = 1; n <= TO + 5; n++) begin
      @(negedge clk);
      if (cmd_start && got == 0) begin got = n; snap(); end
    end
    chk("R6 timeout cycles", got, TO); chk("R6 code", s_code, 3);
    chk("R6 mask", s_mask, 8'hA4); chk("R6 busy", s_busy, 1);

    // R10 suspend, R11 program while suspended, erase refused, resume
    wr(19'h0, 8'hB0);
    chk("R10 start", s_start, 1); chk("R10 code", s_code, 4);
    chk("R10 suspended", s_susp, 1); chk("R10 busy", s_busy, 0);
    unlock2(); wr(19'h5555, 8'hA0); wr(19'h0_0100, 8'h5A);
    chk("R11 program in suspend", s_start, 1); chk("R11 program code", s_code, 1);
    finish_op("R11 program done");
    chk("R11 still suspended", suspended, 1);
    unlock2(); wr(19'h5555, 8'h80); unlock2(); wr(19'h5555, 8'h10);
    chk("R11 erase refused", s_start, 0); chk("R11 refused busy", s_busy, 0);
    wr(19'h3_0000, 8'h30);
    chk("R11 resume start", s_start, 1); chk("R11 resume code", s_code, 5);
    chk("R11 resume busy", s_busy, 1); chk("R11 resume susp", s_susp, 0);
    finish_op("R11 erase done");
    wr(19'h0, 8'hB0);
    chk("R10 suspend ignored idle", s_start, 0); chk("R10 susp flag", s_susp, 0);
    wr(19'h0, 8'h30);
    chk("R11 resume ignored", s_start, 0); chk("R11 busy unchanged", s_busy, 0);

    // R13 foreign write in the window
    erase_setup(); wr(19'h1_0000, 8'h30); wr(19'h1_0000, 8'h55);
    got = 0;
    for (int n = 1; n <= TO + 5; n++) begin
      @(negedge clk);
      if (cmd_start) got = n;
    end
    chk("R13 no start", got, 0); chk("R13 busy", busy, 0);

    // R7/R4 random: corrupt one address step or run clean
    for (int it = 0; it < 40; it++) begin
      int kind, len, bad;
      logic [14:0] la;
      logic [7:0]  ld;
      logic [18:0] a;
      kind = int'($urandom % 2);
      len  = (kind == 0) ? 3 : 6;
      bad  = int'($urandom % (len + 1));
      for (int i = 0; i < len; i++) begin
        step(kind, i, la, ld);
        a = key(la);
        if (i == bad) a[0] = ~a[0];
        wr(a, ld);
        if (kind == 1 && i == len - 1 && bad == len) begin
          chk("R5 random chip", s_start, 1); chk("R5 random mask", s_mask, 8'hFF);
          finish_op("R5 random done");
        end else begin
          chk("R7 random no start", s_start, 0);
        end
        if (i == bad) break;
      end
      if (kind == 0 && bad == len) begin
        ta = 19'($urandom); td = 8'($urandom);
        wr(ta, td);
        chk("R3 random start", s_start, 1); chk("R3 random addr", s_addr, ta);
        chk("R3 random data", s_data, td); chk("R3 random mask", s_mask, exp_mask(ta));
        finish_op("R3 random done");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule